// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire station management bus used between MACs and Ethernet PHYs. Software programs a configuration word (framing variant, preamble on or off, clock divider), a 16-bit write-data word and a command word. Writing the command word launches exactly one management frame. The block divides the system clock down to a management clock, serialises the frame on the data line and, for reads, releases the line, checks the turnaround and captures sixteen data bits.

Both framing variants are supported. Clause 22 frames use start code 01. Clause 45 frames use start code 00. The same two-bit operation code in the command word means different frames depending on the variant bit. Multi-frame sequences, such as a Clause 45 address frame followed by a data frame, are issued by software as separate commands. Completion is observed by polling per-register pending flags. A valid flag reports whether a read succeeded.

Top module: `mdio_master`

## Requirements
- R1: After reset, CFG (select 0) reads 0x0000_0402, WDATA (select 1) and RDATA (select 3) read 0, mdc is low and mdio_oe is low.
- R2: CFG bit 0 selects Clause 45 (1) or Clause 22 (0) framing. CFG bit 1 enables the preamble. CFG bits [15:8] set the half period of mdc in system clocks, with 0 treated as 1. During a frame, consecutive mdc rising edges are exactly two half periods apart, and mdc is low whenever no frame is running.
- R3: Writing CMD (select 2) launches one frame. The fields are operation code [1:0], port address [12:8] and register/device address [20:16]. In Clause 22, code 0 is a write and code 1 is a read. In Clause 45, code 0 is an address frame, code 1 is a write and code 3 is a read.
- R4: The bit order on the line is as follows: 32 ones when the preamble is enabled, then the start field (01 for Clause 22, 00 for Clause 45), then the op field (Clause 22: 01 write, 10 read; Clause 45: 00 address, 01 write, 11 read), then the port address MSB first, then the register address MSB first. After that come two turnaround bits and sixteen data bits. For write and address frames the turnaround is 10 and the data is WDATA[15:0], MSB first.
- R5: The master changes mdio_o only while mdc is low, and it samples mdio_i on mdc rising edges. The master never drives the line while a PHY is expected to drive it.
- R6: On a read, mdio_oe is low from the first turnaround bit to the end of the frame. The sixteen bits the PHY returns land MSB first in RDATA[15:0].
- R7: RDATA bit 30 (valid) is set at the end of a read only if the second turnaround bit was sampled low. Otherwise it stays 0.
- R8: WDATA bit 31 is pending from launch until the last bit of a write or address frame has been shifted out. RDATA bit 31 is pending over the same span for a read. The two are never set together.
- R9: A command written while either pending flag is set is ignored. It launches no frame and does not disturb the running frame.
- R10: Undefined operation codes are ignored: no pending flag is set and no mdc edge occurs. These are codes 2 and 3 in Clause 22, and code 2 in Clause 45.
- R11: Launching any frame clears valid. A write or address frame leaves it cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Register select: 0 CFG, 1 WDATA, 2 CMD, 3 RDATA |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value driven by the master |
| mdio_oe | output | 1 | Master drives the data line when high |
| mdio_i | input | 1 | Resolved data line value |

## Verification
The sweeps cross both framing variants with every defined code, preamble on and off and three divider values. They also walk all 32 port addresses, so a swapped op mapping, a wrong start code or a misplaced field shows up as a bit mismatch at a known position on the line. Reads are run with the second turnaround bit both low and high. A design that ignores the turnaround would report valid on a silent PHY. A design that releases the line one bit late would collide with the responder. Commands that arrive while a frame is running, and undefined codes, are checked by watching for extra mdc edges. A design that accepts either would start a spurious frame or corrupt the one in flight. The divide-by-zero setting is checked so that a design that wraps the counter to 256 is caught by the period check.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PRE_BITS  = 32;
  localparam int BODY_BITS = 32;
  localparam int DATA_W    = 16;
  localparam int FIELD_W   = 5;

  typedef enum logic [1:0] {
    SEL_CFG   = 2'd0,
    SEL_WDATA = 2'd1,
    SEL_CMD   = 2'd2,
    SEL_RDATA = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       legal;
    logic       is_read;
    logic [1:0] start_code;
    logic [1:0] wire_op;
  } op_dec_t;

  // Map the software code to the on-wire fields for the selected variant.
  function automatic op_dec_t decode_op(input logic c45, input logic [1:0] code);
    op_dec_t d;
    d.start_code = c45 ? 2'b00 : 2'b01;
    d.legal      = 1'b0;
    d.is_read    = 1'b0;
    d.wire_op    = 2'b00;
    if (c45) begin
      case (code)
        2'd0: begin d.legal = 1'b1; d.wire_op = 2'b00; end
        2'd1: begin d.legal = 1'b1; d.wire_op = 2'b01; end
        2'd3: begin d.legal = 1'b1; d.wire_op = 2'b11; d.is_read = 1'b1; end
        default: d.legal = 1'b0;
      endcase
    end else begin
      case (code)
        2'd0: begin d.legal = 1'b1; d.wire_op = 2'b01; end
        2'd1: begin d.legal = 1'b1; d.wire_op = 2'b10; d.is_read = 1'b1; end
        default: d.legal = 1'b0;
      endcase
    end
    return d;
  endfunction

  // Frame body after the preamble. A read leaves turnaround and data released (ones).
  function automatic logic [BODY_BITS-1:0] build_body(input op_dec_t d,
                                                      input logic [FIELD_W-1:0] port,
                                                      input logic [FIELD_W-1:0] regad,
                                                      input logic [DATA_W-1:0] data);
    logic [1:0]        ta;
    logic [DATA_W-1:0] payload;
    ta      = d.is_read ? 2'b11 : 2'b10;
    payload = d.is_read ? {DATA_W{1'b1}} : data;
    return {d.start_code, d.wire_op, port, regad, ta, payload};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);

  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap      = run && (cnt == half - 1'b1);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  op_dec_t              start_dec,
  input  logic [FIELD_W-1:0]   start_port,
  input  logic [FIELD_W-1:0]   start_reg,
  input  logic [DATA_W-1:0]    start_wdata,
  input  logic                 start_pre,
  input  logic [DIV_W-1:0]     start_half,
  input  logic                 rise_tick,
  input  logic                 fall_tick,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 done,
  output logic [DIV_W-1:0]     half_q,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic [DATA_W-1:0]    cap_data,
  output logic                 cap_ta_ok
);

  localparam int IDX_W    = $clog2(PRE_BITS + BODY_BITS + 1);
  localparam int TA1_POS  = 2 + 2 + 2 * FIELD_W;
  localparam int TA2_POS  = TA1_POS + 1;
  localparam int DAT_POS  = TA2_POS + 1;

  logic [BODY_BITS-1:0] body_q;
  logic [IDX_W-1:0]     idx;
  logic [IDX_W-1:0]     pos;
  logic                 pre_q;
  logic                 rd_q;
  logic                 in_pre;
  logic                 last_bit;
  logic                 released;

  assign in_pre   = pre_q && (idx < IDX_W'(PRE_BITS));
  assign pos      = pre_q ? idx - IDX_W'(PRE_BITS) : idx;
  assign last_bit = idx == (pre_q ? IDX_W'(PRE_BITS + BODY_BITS - 1) : IDX_W'(BODY_BITS - 1));
  assign released = rd_q && !in_pre && (pos >= IDX_W'(TA1_POS));
  assign done     = busy && fall_tick && last_bit;

  assign mdio_oe  = busy && !released;
  assign mdio_o   = (!busy || in_pre) ? 1'b1 : body_q[BODY_BITS - 1 - int'(pos[$clog2(BODY_BITS)-1:0])];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      body_q    <= '0;
      idx       <= '0;
      pre_q     <= 1'b0;
      rd_q      <= 1'b0;
      half_q    <= DIV_W'(1);
      cap_data  <= '0;
      cap_ta_ok <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy      <= 1'b1;
        body_q    <= build_body(start_dec, start_port, start_reg, start_wdata);
        idx       <= '0;
        pre_q     <= start_pre;
        rd_q      <= start_dec.is_read;
        half_q    <= start_half;
        cap_data  <= '0;
        cap_ta_ok <= 1'b0;
      end
    end else begin
      if (rise_tick && rd_q && !in_pre) begin
        if (pos == IDX_W'(TA2_POS)) begin
          cap_ta_ok <= !mdio_i;
        end else if (pos >= IDX_W'(DAT_POS)) begin
          cap_data <= {cap_data[DATA_W-2:0], mdio_i};
        end
      end
      if (fall_tick) begin
        if (last_bit) begin
          busy <= 1'b0;
          idx  <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int RESET_HALF  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          bus_sel,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                frame_done,
  input  logic [DATA_W-1:0]   cap_data,
  input  logic                cap_ta_ok,
  output logic                start,
  output op_dec_t             start_dec,
  output logic [FIELD_W-1:0]  start_port,
  output logic [FIELD_W-1:0]  start_reg,
  output logic [DATA_W-1:0]   start_wdata,
  output logic                start_pre,
  output logic [DIV_W-1:0]    start_half,
  output logic                wr_pend,
  output logic                rd_pend,
  output logic                rd_valid
);

  localparam int DIV_LSB  = 8;
  localparam int PORT_LSB = 8;
  localparam int REG_LSB  = 16;

  logic              cfg_c45;
  logic              cfg_pre;
  logic [DIV_W-1:0]  cfg_div;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [31:0]       cmd_q;
  logic              cmd_write;

  function automatic logic [DIV_W-1:0] eff_half(input logic [DIV_W-1:0] div);
    return (div == '0) ? DIV_W'(1) : div;
  endfunction

  assign cmd_write   = bus_we && (reg_sel_e'(bus_sel) == SEL_CMD);
  assign start_dec   = decode_op(cfg_c45, bus_wdata[1:0]);
  assign start_port  = bus_wdata[PORT_LSB +: FIELD_W];
  assign start_reg   = bus_wdata[REG_LSB +: FIELD_W];
  assign start_wdata = wdata_q;
  assign start_pre   = cfg_pre;
  assign start_half  = eff_half(cfg_div);
  assign start       = cmd_write && start_dec.legal && !wr_pend && !rd_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_c45  <= 1'b0;
      cfg_pre  <= 1'b1;
      cfg_div  <= DIV_W'(RESET_HALF);
      wdata_q  <= '0;
      rdata_q  <= '0;
      cmd_q    <= '0;
      wr_pend  <= 1'b0;
      rd_pend  <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      if (bus_we && reg_sel_e'(bus_sel) == SEL_CFG) begin
        cfg_c45 <= bus_wdata[0];
        cfg_pre <= bus_wdata[1];
        cfg_div <= bus_wdata[DIV_LSB +: DIV_W];
      end
      if (bus_we && reg_sel_e'(bus_sel) == SEL_WDATA) begin
        wdata_q <= bus_wdata[DATA_W-1:0];
      end
      if (start) begin
        cmd_q    <= bus_wdata;
        wr_pend  <= !start_dec.is_read;
        rd_pend  <= start_dec.is_read;
        rd_valid <= 1'b0;
      end else if (frame_done) begin
        if (rd_pend) begin
          rdata_q  <= cap_data;
          rd_valid <= cap_ta_ok;
        end
        wr_pend <= 1'b0;
        rd_pend <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (reg_sel_e'(bus_sel))
      SEL_CFG: begin
        bus_rdata[0]                 = cfg_c45;
        bus_rdata[1]                 = cfg_pre;
        bus_rdata[DIV_LSB +: DIV_W]  = cfg_div;
      end
      SEL_WDATA: begin
        bus_rdata[31]         = wr_pend;
        bus_rdata[DATA_W-1:0] = wdata_q;
      end
      SEL_CMD: bus_rdata = cmd_q;
      SEL_RDATA: begin
        bus_rdata[31]         = rd_pend;
        bus_rdata[30]         = rd_valid;
        bus_rdata[DATA_W-1:0] = rdata_q;
      end
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int RESET_HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_sel,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  logic               start_pulse;
  logic               frame_done;
  logic               frame_busy;
  logic               rise_tick;
  logic               fall_tick;
  logic               wr_pend;
  logic               rd_pend;
  logic               rd_valid;
  op_dec_t            start_dec;
  logic [FIELD_W-1:0] start_port;
  logic [FIELD_W-1:0] start_reg;
  logic [DATA_W-1:0]  start_wdata;
  logic               start_pre;
  logic [DIV_W-1:0]   start_half;
  logic [DIV_W-1:0]   half_q;
  logic [DATA_W-1:0]  cap_data;
  logic               cap_ta_ok;

  mdio_regs #(.DIV_W(DIV_W), .RESET_HALF(RESET_HALF)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .frame_done  (frame_done),
    .cap_data    (cap_data),
    .cap_ta_ok   (cap_ta_ok),
    .start       (start_pulse),
    .start_dec   (start_dec),
    .start_port  (start_port),
    .start_reg   (start_reg),
    .start_wdata (start_wdata),
    .start_pre   (start_pre),
    .start_half  (start_half),
    .wr_pend     (wr_pend),
    .rd_pend     (rd_pend),
    .rd_valid    (rd_valid)
  );

  mdio_frame #(.DIV_W(DIV_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_pulse),
    .start_dec   (start_dec),
    .start_port  (start_port),
    .start_reg   (start_reg),
    .start_wdata (start_wdata),
    .start_pre   (start_pre),
    .start_half  (start_half),
    .rise_tick   (rise_tick),
    .fall_tick   (fall_tick),
    .mdio_i      (mdio_i),
    .busy        (frame_busy),
    .done        (frame_done),
    .half_q      (half_q),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe),
    .cap_data    (cap_data),
    .cap_ta_ok   (cap_ta_ok)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (frame_busy),
    .half      (half_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

endmodule

// File: rtl/mdio_master_sva.sv
module mdio_master_sva (
  input logic clk,
  input logic rst_n,
  input logic mdc,
  input logic mdio_o,
  input logic start_pulse,
  input logic frame_done,
  input logic frame_busy,
  input logic wr_pend,
  input logic rd_pend,
  input logic rd_valid
);

  AST_DRIVE_WHILE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> !mdc); // R5

  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_busy |-> !mdc); // R2

  AST_PENDING_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_pend, rd_pend})); // R8

  AST_NO_LAUNCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !frame_busy); // R9

  AST_LAUNCH_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !rd_valid && (wr_pend || rd_pend)); // R11

  AST_DONE_DROPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !wr_pend && !rd_pend && !frame_busy); // R8

  AST_VALID_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(frame_done)); // R7

endmodule

bind mdio_master mdio_master_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .mdc         (mdc),
  .mdio_o      (mdio_o),
  .start_pulse (start_pulse),
  .frame_done  (frame_done),
  .frame_busy  (frame_busy),
  .wr_pend     (wr_pend),
  .rd_pend     (rd_pend),
  .rd_valid    (rd_valid)
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;

  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_sel = 2'd0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_oe = 1'b0;
  logic        phy_bit = 1'b1;

  assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_bit : 1'b1);

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .mdio_i    (mdio_i)
  );

  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  bit          finished = 0;
  logic        prev_mdc = 1'b0;
  logic        prev_o = 1'b1;
  int          rise_cnt = 0;
  logic [63:0] cap_bits = '0;
  int          last_rise = 0;
  bit          have_rise = 0;
  bit          period_bad = 0;
  int          cur_half = 1;
  int          r5_bad = 0;
  int          clash = 0;
  bit          phy_rd = 0;
  int          phy_base = 0;
  logic        phy_ta2 = 1'b0;
  logic [15:0] phy_data = '0;

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Responder and line monitor, all on the inactive clock edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mdio_o !== prev_o && mdc) r5_bad++;
      if (mdio_oe && phy_oe) clash++;
      if (mdc && !prev_mdc) begin
        if (rise_cnt < 64) cap_bits[rise_cnt] = mdio_i;
        rise_cnt++;
        if (have_rise && (cyc - last_rise) != 2 * cur_half) period_bad = 1;
        have_rise = 1;
        last_rise = cyc;
      end
      if (!mdc && prev_mdc) begin
        if (phy_rd && rise_cnt >= phy_base + 15 && rise_cnt < phy_base + 32) begin
          phy_oe  = 1'b1;
          phy_bit = (rise_cnt == phy_base + 15) ? phy_ta2 : phy_data[31 - (rise_cnt - phy_base)];
        end else begin
          phy_oe = 1'b0;
        end
      end
    end
    prev_mdc = mdc;
    prev_o   = mdio_o;
    if (cyc > WATCHDOG_CYCLES && !finished) begin
      errors++;
      $display("FAIL R8: watchdog expired at cycle %0d, expected completion before %0d", cyc, WATCHDOG_CYCLES);
      report();
      $finish;
    end
  end

  task automatic bus_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_sel   = s;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] s, output logic [31:0] v);
    bus_sel = s;
    #1;
    v = bus_rdata;
  endtask

  task automatic wait_idle;
    logic [31:0] a, b;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      bus_read(2'd1, a);
      bus_read(2'd3, b);
      if (!a[31] && !b[31]) break;
    end
  endtask

  function automatic logic [31:0] cmd_word(input logic [1:0] code, input logic [4:0] port, input logic [4:0] regad);
    return (32'(regad) << 16) | (32'(port) << 8) | 32'(code);
  endfunction

  task automatic run_frame(input bit c45, input bit pre, input int half, input logic [1:0] code,
                           input logic [4:0] port, input logic [4:0] regad, input logic [15:0] wd,
                           input logic ta2, input logic [15:0] pd, input bit intrude);
    bit          rd;
    logic [31:0] r;
    logic [1:0]  st, wop;
    logic [31:0] body;
    logic [63:0] line;
    int          len, mism, rises_end;
    rd  = c45 ? (code == 2'd3) : (code == 2'd1);
    st  = c45 ? 2'b00 : 2'b01;
    wop = c45 ? code : code + 2'd1;
    body = rd ? {st, wop, port, regad, 1'b1, ta2, pd} : {st, wop, port, regad, 2'b10, wd};
    len  = pre ? 64 : 32;
    line = pre ? {32'hFFFF_FFFF, body} : {32'h0, body};
    bus_write(2'd0, (32'(half & 255) << 8) | (32'(pre) << 1) | 32'(c45));
    bus_write(2'd1, {16'h0, wd});
    rise_cnt = 0; have_rise = 0; period_bad = 0; r5_bad = 0; clash = 0;
    cur_half = (half == 0) ? 1 : half;
    phy_rd = rd; phy_base = pre ? 32 : 0; phy_ta2 = ta2; phy_data = pd;
    bus_write(2'd2, cmd_word(code, port, regad));
    bus_read(2'd1, r);
    check(r[31] == !rd, "R8 wdata pending after launch", 64'(r[31]), 64'(!rd));
    bus_read(2'd3, r);
    check(r[31] == rd && r[30] == 1'b0, "R11 rdata pending/valid after launch", 64'(r[31:30]), 64'({rd, 1'b0}));
    if (intrude) begin
      repeat (20) @(negedge clk);
      bus_write(2'd2, cmd_word(2'd0, ~port, ~regad));
    end
    wait_idle();
    rises_end = rise_cnt;
    check(rise_cnt == len, "R4 frame length in mdc cycles", 64'(rise_cnt), 64'(len));
    mism = 0;
    for (int i = 0; i < len; i++) if (cap_bits[i] !== line[len - 1 - i]) mism++;
    check(mism == 0, rd ? "R6 read frame bits" : "R4 write/address frame bits", cap_bits, line);
    check(!period_bad, "R2 mdc period", 64'(period_bad), 64'(0));
    check(r5_bad == 0 && clash == 0, "R5 line changes with mdc high or contention", 64'(r5_bad + clash), 64'(0));
    if (rd) begin
      bus_read(2'd3, r);
      check(r[30] == (ta2 == 1'b0), "R7 valid after read", 64'(r[30]), 64'(ta2 == 1'b0));
      if (ta2 == 1'b0) check(r[15:0] == pd, "R6 captured read data", 64'(r[15:0]), 64'(pd));
    end
    if (intrude) begin
      repeat (100) @(negedge clk);
      check(rise_cnt == rises_end, "R9 command during pending started a frame", 64'(rise_cnt), 64'(rises_end));
      bus_read(2'd1, r);
      check(r[31] == 1'b0, "R9 no pending after ignored command", 64'(r[31]), 64'(0));
    end
  endtask

  task automatic illegal_cmd(input bit c45, input logic [1:0] code);
    logic [31:0] a, b;
    bus_write(2'd0, (32'd1 << 8) | 32'(c45));
    rise_cnt = 0;
    bus_write(2'd2, cmd_word(code, 5'd3, 5'd9));
    bus_read(2'd1, a);
    bus_read(2'd3, b);
    check(!a[31] && !b[31], "R10 undefined code set pending", 64'({a[31], b[31]}), 64'(0));
    repeat (50) @(negedge clk);
    check(rise_cnt == 0, "R10 undefined code produced mdc edges", 64'(rise_cnt), 64'(0));
  endtask

  initial begin
    logic [31:0] r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    bus_read(2'd0, r); check(r == 32'h0000_0402, "R1 CFG reset", 64'(r), 64'h402);
    bus_read(2'd1, r); check(r == 32'h0, "R1 WDATA reset", 64'(r), 64'h0);
    bus_read(2'd3, r); check(r == 32'h0, "R1 RDATA reset", 64'(r), 64'h0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 line idle", 64'({mdc, mdio_oe}), 64'(0));

    // R3 R4 R6 R7: both variants, every defined code, preamble and divider sweep
    for (int c45 = 0; c45 < 2; c45++)
      for (int code = 0; code < 4; code++) begin
        if ((c45 == 0 && code >= 2) || (c45 == 1 && code == 2)) continue;
        for (int pre = 0; pre < 2; pre++)
          for (int h = 1; h <= 3; h++)
            run_frame(c45[0], pre[0], h, code[1:0], 5'((c45 * 16 + code * 5 + h * 3 + pre) & 31),
                      5'((code * 11 + h * 7 + c45) & 31), 16'((h * 16'h1357) ^ (code << 12) ^ pre),
                      (h == 2 && pre == 0) ? 1'b1 : 1'b0, 16'(16'hA5C3 ^ (h << 4) ^ code), 1'b0);
      end

    // R3 port/register address walk
    for (int i = 0; i < 32; i++)
      run_frame(1'b0, 1'b0, 1, 2'd0, 5'(i), 5'(31 - i), 16'(i * 16'h0801), 1'b0, 16'h0, 1'b0);

    // R6 data walk on reads
    for (int i = 0; i < 8; i++)
      run_frame(1'b1, 1'b0, 1, 2'd3, 5'(i), 5'(i + 8), 16'h0, 1'b0, 16'((16'h1 << (i * 2)) ^ 16'h8001), 1'b0);

    // R2 divider field zero behaves as one
    run_frame(1'b0, 1'b1, 0, 2'd1, 5'd7, 5'd2, 16'h0, 1'b0, 16'h3C3C, 1'b0);

    // R9 command while pending
    run_frame(1'b0, 1'b1, 2, 2'd1, 5'd12, 5'd4, 16'h0, 1'b0, 16'hBEEF, 1'b1);

    // R11 valid cleared by a following write and stays cleared
    run_frame(1'b1, 1'b0, 1, 2'd3, 5'd1, 5'd1, 16'h0, 1'b0, 16'h1234, 1'b0);
    run_frame(1'b1, 1'b0, 1, 2'd1, 5'd1, 5'd1, 16'h5678, 1'b0, 16'h0, 1'b0);
    bus_read(2'd3, r);
    check(r[30] == 1'b0, "R11 valid after write frame", 64'(r[30]), 64'(0));

    // R10 undefined codes
    illegal_cmd(1'b0, 2'd2);
    illegal_cmd(1'b0, 2'd3);
    illegal_cmd(1'b1, 2'd2);

    finished = 1;
    report();
    $finish;
  end

endmodule